// File: doc/BRIEF.md
# Configurable Logic Cell

A configurable logic cell that computes two four-input functions from lookup tables, a third three-input function that merges both table results with one extra input, and two storage elements whose behaviour is chosen by configuration. A wider fabric builds it many times over. Each cell is given its table contents and mode bits through a plain parallel configuration port. After that it acts as a small, fixed piece of logic with two combinational and two registered results.

The whole cell runs on one system clock `clk`. The cell's own clock, `cell_clk`, is a data input sampled by that clock. A flip-flop edge is seen at the system edge where the sampled `cell_clk` differs from the value held on the previous system edge. A latch is transparent on every system edge where `cell_clk` is at its active level. "Asynchronous" set/clear means the request acts on the next system edge whatever `cell_clk` and the clock enable are doing. "Synchronous" set/clear acts only at an active storage event.

Configuration word layout (LSB first): bits 15:0 first table (F), bits 31:16 second table (G), bits 39:32 merge table (H), bits 45:40 element 0 settings, bits 51:46 element 1 settings. Inside each 6-bit element field: bit 0 polarity invert, bit 1 latch mode, bit 2 asynchronous set/clear, bits 4:3 data source, bit 5 combinational output shows H.

Top module: `clb_cell`

## Requirements
- R1: While `cfg_we` is high, `cfg_word` is stored at the next `clk` edge. While `cfg_we` is low, the stored configuration is unchanged.
- R2: When an element's bit 5 is 0, `comb_out[0]` equals F table bit `a_in` and `comb_out[1]` equals G table bit `b_in`. These change combinationally with the inputs.
- R3: When element i's bit 5 is 1, `comb_out[i]` equals H table bit at index {`c_in`, G result, F result}, with `c_in` as the MSB.
- R4: The data source field selects the storage input: 0 = F result, 1 = G result, 2 = H result, 3 = `d_in`.
- R5: In flip-flop mode (bit 1 = 0), polarity 0 captures when sampled `cell_clk` goes 0 to 1, and polarity 1 captures when it goes 1 to 0. `reg_out` changes right after that `clk` edge and holds at every other edge.
- R6: In latch mode (bit 1 = 1), the element follows its data source at each `clk` edge where `cell_clk` equals the inverse of its polarity bit. It holds otherwise.
- R7: With `cell_ce` low and no set or clear request, neither storage element changes.
- R8: With bit 2 = 1, `clr_in` forces the element to 0 and `set_in` forces it to 1 at the next `clk` edge, regardless of `cell_clk` and `cell_ce`.
- R9: With bit 2 = 0, set and clear act only at an active flip-flop edge or latch level, even when `cell_ce` is low. They have no effect at other edges.
- R10: When `set_in` and `clr_in` are both high, the element is cleared, in both the synchronous and the asynchronous case.
- R11: `rst` high at a `clk` edge clears the configuration, both storage elements and the sampled `cell_clk` history, so both outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_word | input | 52 | Configuration word (tables and mode bits) |
| a_in | input | 4 | Address inputs of table F |
| b_in | input | 4 | Address inputs of table G |
| c_in | input | 1 | Extra input of merge function H |
| d_in | input | 1 | Direct data input for storage |
| cell_clk | input | 1 | Cell clock, sampled by `clk` |
| cell_ce | input | 1 | Storage clock enable |
| set_in | input | 1 | Set request |
| clr_in | input | 1 | Clear request |
| comb_out | output | 2 | Combinational results |
| reg_out | output | 2 | Storage element states |

## Verification
The bench uses the default four-input tables. It loads two configurations that between them reach every data source and both polarities in flip-flop and latch mode. In each configuration one element is synchronous and the other asynchronous, so the same set/clear stimulus shows both behaviours side by side. Majority, parity and all-ones table contents make every vector of the combinational table give a result that can be worked out by hand.

// File: rtl/clb_pkg.sv
package clb_pkg;

    localparam int LUT_K  = 4;
    localparam int LUT_W  = 1 << LUT_K;
    localparam int MRG_K  = 3;
    localparam int MRG_W  = 1 << MRG_K;
    localparam int NUM_ST = 2;

    typedef enum logic [1:0] {
        SRC_F   = 2'd0,
        SRC_G   = 2'd1,
        SRC_H   = 2'd2,
        SRC_DIN = 2'd3
    } src_t;

    typedef struct packed {
        logic comb_h;
        src_t dsel;
        logic sr_async;
        logic latch;
        logic inv;
    } store_cfg_t;

    typedef struct packed {
        store_cfg_t [NUM_ST-1:0] st;
        logic [MRG_W-1:0]        h_tab;
        logic [LUT_W-1:0]        g_tab;
        logic [LUT_W-1:0]        f_tab;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    function automatic logic pick_src(src_t s, logic f, logic g, logic h, logic d);
        case (s)
            SRC_F:   return f;
            SRC_G:   return g;
            SRC_H:   return h;
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/clb_lut.sv
module clb_lut #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] tab,
    input  logic [K-1:0]      sel,
    output logic              y
);
    assign y = tab[sel];
endmodule

// File: rtl/clb_store.sv
module clb_store
    import clb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  store_cfg_t scfg,
    input  logic       d,
    input  logic       cell_clk,
    input  logic       clk_seen,
    input  logic       ce,
    input  logic       set_i,
    input  logic       clr_i,
    output logic       q
);
    logic lvl_now;
    logic lvl_was;
    logic active;

    // Active level after polarity: high means "clock asserted" for this element
    assign lvl_now = cell_clk ^ scfg.inv;
    assign lvl_was = clk_seen ^ scfg.inv;
    assign active  = scfg.latch ? lvl_now : (lvl_now & ~lvl_was);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (scfg.sr_async && clr_i) begin
            q <= 1'b0;
        end else if (scfg.sr_async && set_i) begin
            q <= 1'b1;
        end else if (active) begin
            if (clr_i)       q <= 1'b0;
            else if (set_i)  q <= 1'b1;
            else if (ce)     q <= d;
        end
    end
endmodule

// File: rtl/clb_cell.sv
module clb_cell
    import clb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [LUT_K-1:0]  a_in,
    input  logic [LUT_K-1:0]  b_in,
    input  logic              c_in,
    input  logic              d_in,
    input  logic              cell_clk,
    input  logic              cell_ce,
    input  logic              set_in,
    input  logic              clr_in,
    output logic [NUM_ST-1:0] comb_out,
    output logic [NUM_ST-1:0] reg_out
);
    cell_cfg_t         cfg_q;
    logic              clk_seen;
    logic              f_y, g_y, h_y;
    logic [NUM_ST-1:0] base_y;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= cell_cfg_t'(cfg_word);
    end

    always_ff @(posedge clk) begin
        if (rst) clk_seen <= 1'b0;
        else     clk_seen <= cell_clk;
    end

    clb_lut #(.K(LUT_K)) u_lut_f (.tab(cfg_q.f_tab), .sel(a_in), .y(f_y));
    clb_lut #(.K(LUT_K)) u_lut_g (.tab(cfg_q.g_tab), .sel(b_in), .y(g_y));
    clb_lut #(.K(MRG_K)) u_lut_h (.tab(cfg_q.h_tab), .sel({c_in, g_y, f_y}), .y(h_y));

    assign base_y = {g_y, f_y};

    for (genvar i = 0; i < NUM_ST; i++) begin : g_elem
        logic d_sel;
        assign d_sel       = pick_src(cfg_q.st[i].dsel, f_y, g_y, h_y, d_in);
        assign comb_out[i] = cfg_q.st[i].comb_h ? h_y : base_y[i];

        clb_store u_store (
            .clk      (clk),
            .rst      (rst),
            .scfg     (cfg_q.st[i]),
            .d        (d_sel),
            .cell_clk (cell_clk),
            .clk_seen (clk_seen),
            .ce       (cell_ce),
            .set_i    (set_in),
            .clr_i    (clr_in),
            .q        (reg_out[i])
        );
    end
endmodule

// File: rtl/clb_cell_chk.sv
module clb_cell_chk
    import clb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_word,
    input cell_cfg_t         cfg_q,
    input logic              clk_seen,
    input logic              cell_clk,
    input logic              cell_ce,
    input logic              set_in,
    input logic              clr_in,
    input logic [NUM_ST-1:0] reg_out
);
    assert_cfg_load_R1: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_q == cell_cfg_t'($past(cfg_word))));

    assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q));

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (reg_out == '0) && (cfg_q == '0) && !clk_seen);

    for (genvar i = 0; i < NUM_ST; i++) begin : g_chk
        assert_async_clr_R8: assert property (@(posedge clk) disable iff (rst)
            (cfg_q.st[i].sr_async && clr_in) |=> !reg_out[i]);

        assert_async_set_R8: assert property (@(posedge clk) disable iff (rst)
            (cfg_q.st[i].sr_async && set_in && !clr_in) |=> reg_out[i]);

        assert_clr_wins_R10: assert property (@(posedge clk) disable iff (rst)
            (cfg_q.st[i].sr_async && set_in && clr_in) |=> !reg_out[i]);

        assert_ce_hold_R7: assert property (@(posedge clk) disable iff (rst)
            (!cell_ce && !set_in && !clr_in) |=> $stable(reg_out[i]));

        assert_ff_no_edge_R5: assert property (@(posedge clk) disable iff (rst)
            (!cfg_q.st[i].latch && (cell_clk == clk_seen) &&
             !(cfg_q.st[i].sr_async && (set_in || clr_in))) |=> $stable(reg_out[i]));
    end
endmodule

bind clb_cell clb_cell_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_word (cfg_word),
    .cfg_q    (cfg_q),
    .clk_seen (clk_seen),
    .cell_clk (cell_clk),
    .cell_ce  (cell_ce),
    .set_in   (set_in),
    .clr_in   (clr_in),
    .reg_out  (reg_out)
);

// File: tb/test_clb_cell.sv
module test_clb_cell;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [51:0] cfg_word;
    logic [3:0]  a_in, b_in;
    logic        c_in, d_in, cell_clk, cell_ce, set_in, clr_in;
    logic [1:0]  comb_out, reg_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    clb_cell i_clb_cell (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
        .cell_clk(cell_clk), .cell_ce(cell_ce), .set_in(set_in), .clr_in(clr_in),
        .comb_out(comb_out), .reg_out(reg_out)
    );

    // element field: {comb_h, dsel[1:0], async, latch, inv}
    localparam logic [5:0]  C1_S0 = 6'b0_00_0_0_0;
    localparam logic [5:0]  C1_S1 = 6'b1_11_1_0_1;
    localparam logic [5:0]  C2_S0 = 6'b0_01_0_1_0;
    localparam logic [5:0]  C2_S1 = 6'b0_10_1_1_1;
    localparam logic [51:0] CFG1  = {C1_S1, C1_S0, 8'hE8, 16'h6996, 16'h8000};
    localparam logic [51:0] CFG2  = {C2_S1, C2_S0, 8'hE8, 16'h6996, 16'h8000};

    // {a, b, c, expected comb_out}; F = all ones, G = parity, comb1 = majority H
    localparam logic [10:0] VEC [0:7] = '{
        {4'hF, 4'h0, 1'b0, 2'b01},
        {4'hF, 4'h1, 1'b0, 2'b11},
        {4'h7, 4'h3, 1'b1, 2'b00},
        {4'hE, 4'h7, 1'b1, 2'b10},
        {4'hF, 4'h8, 1'b1, 2'b11},
        {4'h0, 4'hF, 1'b1, 2'b00},
        {4'hF, 4'h5, 1'b1, 2'b11},
        {4'h3, 4'hE, 1'b0, 2'b00}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_word = '0; a_in = 0; b_in = 0; c_in = 0; d_in = 0;
        cell_clk = 0; cell_ce = 0; set_in = 0; clr_in = 0;
        tick(); tick();
        chk("R11 reset reg", reg_out, 2'b00);
        chk("R11 reset comb", comb_out, 2'b00);
        rst = 0;

        // R1 load then hold
        cfg_we = 1; cfg_word = CFG1; tick();
        cfg_we = 0; cfg_word = '1; a_in = 4'hF; b_in = 0; c_in = 0; tick();
        chk("R1 config held", comb_out, 2'b01);

        // R2 R3 table walk
        for (int k = 0; k < 8; k++) begin
            a_in = VEC[k][10:7]; b_in = VEC[k][6:3]; c_in = VEC[k][2];
            #1;
            chk("R2 R3 comb vector", comb_out, VEC[k][1:0]);
        end

        // R5 R4 flip-flop edges: elem0 rising from F, elem1 falling from d_in
        a_in = 4'hF; b_in = 0; c_in = 0; d_in = 1; cell_ce = 1; cell_clk = 0; tick();
        chk("R5 no edge", reg_out, 2'b00);
        cell_clk = 1; tick();
        chk("R5 R4 rising capture F", reg_out, 2'b01);
        a_in = 0; tick();
        chk("R5 hold between edges", reg_out, 2'b01);
        cell_clk = 0; tick();
        chk("R5 R4 falling capture din", reg_out, 2'b11);

        // R7 clock enable low
        cell_ce = 0; cell_clk = 1; tick();
        chk("R7 ce low blocks edge", reg_out, 2'b11);
        cell_ce = 1; cell_clk = 0; tick();
        cell_clk = 1; tick();
        chk("R5 rising captures F=0", reg_out, 2'b10);

        // R8 R9 R10 with cell_clk steady
        cell_ce = 0; clr_in = 1; tick();
        chk("R8 async clear", reg_out, 2'b00);
        clr_in = 0; set_in = 1; tick();
        chk("R8 R9 async set, sync idle", reg_out, 2'b10);
        clr_in = 1; tick();
        chk("R10 async clear wins", reg_out, 2'b00);
        set_in = 0; clr_in = 0;

        // R9 synchronous set/clear at edges, ce low
        set_in = 1; cell_clk = 0; tick();
        chk("R9 sync set waits for edge", reg_out, 2'b10);
        cell_clk = 1; tick();
        chk("R9 sync set at edge", reg_out, 2'b11);
        clr_in = 1; cell_clk = 0; tick();
        chk("R9 sync clear waits", reg_out, 2'b01);
        cell_clk = 1; tick();
        chk("R10 sync clear wins", reg_out, 2'b00);
        set_in = 0; clr_in = 0;

        // R6 latch mode
        cfg_we = 1; cfg_word = CFG2; tick();
        cfg_we = 0;
        cell_ce = 1; a_in = 0; b_in = 4'h1; c_in = 1; tick();
        chk("R6 R4 latch follows G", reg_out, 2'b01);
        chk("R2 comb shows F and G", comb_out, 2'b10);
        b_in = 4'h3; tick();
        chk("R6 latch follows low", reg_out, 2'b00);
        b_in = 4'h1; tick();
        chk("R6 latch follows high", reg_out, 2'b01);
        cell_clk = 0; b_in = 4'h3; tick();
        chk("R6 opaque hold, low-transparent H", reg_out, 2'b01);
        a_in = 4'hF; b_in = 4'h0; tick();
        chk("R6 R4 latch follows H", reg_out, 2'b11);
        a_in = 4'h0; tick();
        chk("R6 latch tracks H again", reg_out, 2'b01);

        // R11 reset mid-run
        rst = 1; tick();
        chk("R11 reset reg", reg_out, 2'b00);
        chk("R11 reset tables", comb_out, 2'b00);
        rst = 0; tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule